// File: doc/BRIEF.md
# PC-relative address load unit

This unit works out the value that an address-load instruction writes into a pointer register. Each cycle it can accept one 32-bit instruction word together with the program counter of that instruction. It recognises the address-load opcode and decodes the destination field, the relative/absolute mode bit and the 20-bit immediate. One clock later it presents the destination select, the 20-bit address zero-extended to 32 bits, and a write strobe.

In absolute mode the immediate is passed through unchanged. In relative mode the immediate is a two's-complement offset. It is added to the address of the instruction that follows, and that address depends on where the code runs:

- A program counter below 0x400 means code is running from the word-addressed local memory, so the next address is PC+1.
- At 0x400 and above, code is running from the byte-addressed shared memory, so the next address is PC+4.

Because of this, a relative form and an absolute form that name the same label load the same runtime value, and position-independent code keeps working after it is moved.

Top module: `ptr_load_unit`

## Requirements
- R1: When `in_valid` is high and `instr[31:23]` equals 9'h1FD, `wr_en` is high exactly one clock later. Otherwise `wr_en` is low one clock later.
- R2: On an accepted word, `wr_sel` equals `instr[22:21]` one clock later. The value 2'b00 selects pointer register A and 2'b01 selects pointer register B. For example, 0xFE9xxxxx targets A and 0xFEAxxxxx targets B.
- R3: When `instr[20]` is 0 (absolute mode), `wr_data[19:0]` equals `instr[19:0]` for any program counter.
- R4: When `instr[20]` is 1 (relative mode) and `pc` >= 0x400, `wr_data[19:0]` equals (pc + 4 + imm) mod 2^20. For example, 0xFE90001C at 0x408 yields 0x428, and 0xFE900008 at 0x400 yields 0x40C.
- R5: When `instr[20]` is 1 and `pc` < 0x400, `wr_data[19:0]` equals (pc + 1 + imm) mod 2^20.
- R6: In relative mode a negative offset is encoded in two's complement in bits 19:0 (for example 0xFFFE0 is -32). The sum wraps modulo 2^20.
- R7: `wr_data[31:20]` is always zero.
- R8: After reset, `wr_en`, `wr_sel` and `wr_data` are all zero.
- R9: A word that is not accepted leaves `wr_sel` and `wr_data` unchanged.
- R10: The domain boundary is exact. A `pc` of 0x3FF steps by 1 and a `pc` of 0x400 steps by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word present this cycle |
| instr | input | 32 | Instruction word |
| pc | input | 20 | Address of the instruction |
| wr_en | output | 1 | Pointer register write strobe |
| wr_sel | output | 2 | Destination register field |
| wr_data | output | 32 | Value to write, zero-extended |

## Verification
Every result (strobe, select and data) appears one register stage after the word is presented. The bench therefore drives a word on a falling edge and compares all three outputs on the following falling edge, before the next word is applied. Ignored words are checked in the same way: in that cycle the strobe must be low and the select and data must still hold the previous accepted result. A sweep crosses program counters on both sides of 0x400 and at the top of the address space with offsets that include zero, large positive values and negative values, in both modes and for every destination field value.

// File: rtl/ptr_load_unit.sv
module ptr_load_unit #(
  parameter int            AW           = 20,
  parameter int            DW           = 32,
  parameter logic [AW-1:0] SHARED_FLOOR = 'h400,
  parameter int            WORD_STEP    = 1,
  parameter int            BYTE_STEP    = 4,
  parameter logic [8:0]    OPCODE       = 9'h1FD
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [31:0]   instr,
  input  logic [AW-1:0] pc,
  output logic          wr_en,
  output logic [1:0]    wr_sel,
  output logic [DW-1:0] wr_data
);

  localparam int PADW = DW - AW;

  logic          hit, rel, word_dom;
  logic [AW-1:0] imm, step, next_pc, target;

  assign hit      = in_valid && (instr[31:23] == OPCODE);
  assign rel      = instr[AW];
  assign imm      = instr[AW-1:0];
  assign word_dom = pc < SHARED_FLOOR;
  assign step     = word_dom ? AW'(WORD_STEP) : AW'(BYTE_STEP);
  assign next_pc  = pc + step;
  assign target   = rel ? (next_pc + imm) : imm;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_en   <= 1'b0;
      wr_sel  <= 2'b00;
      wr_data <= '0;
    end else begin
      wr_en <= hit;
      if (hit) begin
        wr_sel  <= instr[22:21];
        wr_data <= {{PADW{1'b0}}, target};
      end
    end
  end

  a_r1_strobe_off: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && (instr[31:23] == OPCODE)) |=> !wr_en);

  a_r2_dst_field: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (instr[31:23] == OPCODE)) |=> (wr_en && wr_sel == $past(instr[22:21])));

  a_r3_abs_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (instr[31:23] == OPCODE) && !instr[AW]) |=> (wr_data[AW-1:0] == $past(instr[AW-1:0])));

  a_r5_word_rel: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (instr[31:23] == OPCODE) && instr[AW] && (pc < SHARED_FLOOR))
    |=> (wr_data[AW-1:0] == AW'($past(pc) + AW'(WORD_STEP) + $past(instr[AW-1:0]))));

  a_r7_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data[DW-1:AW] == '0);

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && (instr[31:23] == OPCODE)) |=> ($stable(wr_data) && $stable(wr_sel)));

endmodule

// File: tb/sim_ptr_load_unit.sv
module sim_ptr_load_unit;
  localparam int CLK_P = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        in_valid = 0;
  logic [31:0] instr = '0;
  logic [19:0] pc = '0;
  logic        wr_en;
  logic [1:0]  wr_sel;
  logic [31:0] wr_data;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] last_data = '0;
  logic [1:0]  last_sel = '0;

  always #(CLK_P/2) clk = ~clk;

  ptr_load_unit u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
                    .pc(pc), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [19:0] model(input logic [31:0] w, input logic [19:0] p);
    logic [19:0] nxt;
    nxt = p + ((p < 20'h400) ? 20'd1 : 20'd4);
    return w[20] ? 20'(nxt + w[19:0]) : w[19:0];
  endfunction

  task automatic issue(input logic v, input logic [31:0] w, input logic [19:0] p, input string tag);
    logic acc;
    @(negedge clk);
    in_valid = v; instr = w; pc = p;
    @(negedge clk);
    in_valid = 0;
    acc = v && (w[31:23] == 9'h1FD);
    chk({tag, " R1 strobe"}, {31'd0, wr_en}, {31'd0, acc});
    if (acc) begin
      last_data = {12'd0, model(w, p)};
      last_sel  = w[22:21];
      chk({tag, " R2 sel"}, {30'd0, wr_sel}, {30'd0, last_sel});
      chk({tag, w[20] ? ((p < 20'h400) ? " R5 word rel" : " R4 byte rel") : " R3 abs"},
          wr_data, last_data);
    end else begin
      chk({tag, " R9 hold data"}, wr_data, last_data);
      chk({tag, " R9 hold sel"}, {30'd0, wr_sel}, {30'd0, last_sel});
    end
    chk({tag, " R7 upper"}, {20'd0, wr_data[31:20]}, 32'd0);
  endtask

  initial begin
    #(CLK_P * 100000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [19:0] pcs [10];
    logic [19:0] imms [8];
    pcs  = '{20'h0, 20'h1, 20'hF, 20'h3FE, 20'h3FF, 20'h400, 20'h401, 20'h408, 20'hFFFFC, 20'hFFFFF};
    imms = '{20'h0, 20'h1, 20'h1C, 20'h7FFFF, 20'h80000, 20'hFFFE0, 20'hFFFFF, 20'h110};
    repeat (3) @(negedge clk);
    chk("R8 reset en", {31'd0, wr_en}, 32'd0);
    chk("R8 reset sel", {30'd0, wr_sel}, 32'd0);
    chk("R8 reset data", wr_data, 32'd0);
    rst_n = 1;

    issue(1, 32'hFE90001C, 20'h408, "R4 ex1");
    chk("R4 0x428", wr_data, 32'h428);
    issue(1, 32'hFE900008, 20'h400, "R4 ex2");
    chk("R4 0x40C rel", wr_data, 32'h40C);
    issue(1, 32'hFEA0040C, 20'h404, "R3 ex3");
    chk("R3 0x40C abs", wr_data, 32'h40C);
    chk("R2 reg B", {30'd0, wr_sel}, 32'd1);
    issue(1, 32'hFE800110, 20'h00F, "R3 word abs");
    chk("R3 0x110", wr_data, 32'h110);
    issue(1, 32'hFE9FFFE0, 20'h00F, "R6 neg word");
    chk("R6 wrap", wr_data, 32'hFFFF0);
    issue(1, 32'hFE900000, 20'h3FF, "R10 0x3FF");
    chk("R10 step1", wr_data, 32'h400);
    issue(1, 32'hFE900000, 20'h400, "R10 0x400");
    chk("R10 step4", wr_data, 32'h404);
    issue(1, 32'hFF900000, 20'h400, "R1 bad opcode");
    issue(1, 32'h7E900000, 20'h400, "R1 bad msb");
    issue(0, 32'hFE900010, 20'h500, "R9 invalid");

    for (int i = 0; i < 10; i++)
      for (int j = 0; j < 8; j++)
        for (int m = 0; m < 2; m++) begin
          logic [31:0] w;
          w = {9'h1FD, 2'((i + j) % 4), m[0], imms[j]};
          issue(1, w, pcs[i], "sweep");
          if ((i + j + m) % 7 == 0)
            issue(1, {9'h0FD, 2'b11, m[0], imms[j]}, pcs[i], "R9 sweep ignore");
        end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule